// File: doc/BRIEF.md
# Dead-Time Complementary Output Stage

This block sits behind a PWM counter and turns its preliminary level into a pair of complementary switch drives. When the preliminary level changes, the drive that is turning off goes inactive at once, and the drive that is turning on waits a programmable number of clock cycles before it goes active. During that window both drives are off, which keeps a half-bridge from shooting through.

The dead time is counted on the undivided clock, with no prescaler. An emergency kill input forces both drives inactive in the same cycle, and the dead-time logic keeps running underneath. Each drive has its own polarity bit, applied last, so "inactive" means the level selected by that bit.

Top module: `dtcomp_stage`

## Requirements
- R1: While reset is asserted, neither drive is active, so `pwm` equals `inv_true` and `pwm_n` equals `inv_comp`.
- R2: When a clock edge samples `pwm_pre` going from 0 to 1 with `dt_cycles` = D > 0, the complementary drive is inactive after that edge and the true drive becomes active exactly D edges later.
- R3: When a clock edge samples `pwm_pre` going from 1 to 0 with D > 0, the true drive is inactive after that edge and the complementary drive becomes active exactly D edges later.
- R4: With `dt_cycles` = 0, the true drive follows `pwm_pre` after the sampling edge and the complementary drive is its exact inverse, with no dead window.
- R5: If `pwm_pre` changes back before the dead window ends, the drive that was waiting never goes active, and a new window of the current D starts from the new change.
- R6: The dead time is taken from `dt_cycles` at the edge that samples the change. Changing `dt_cycles` during a window does not alter that window.
- R7: While `kill` is 1, both drives are inactive in the same cycle, without waiting for a clock edge. The dead-time timeline keeps running, so the drives resume in their current state when `kill` returns to 0.
- R8: Polarity is applied after kill gating: `pwm` = active_true XOR `inv_true`, and `pwm_n` = active_comp XOR `inv_comp`. The two bits are independent.
- R9: The true and complementary drives are never active at the same time.
- R10: After reset is released, the first clock edge that samples `pwm_pre` = 0 makes the complementary drive active. If that first edge samples 1, it starts a dead window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock, not prescaled |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwm_pre | input | 1 | Preliminary PWM level from the counter |
| dt_cycles | input | 8 | Dead time in clock cycles |
| inv_true | input | 1 | Polarity inversion for the true drive |
| inv_comp | input | 1 | Polarity inversion for the complementary drive |
| kill | input | 1 | Forces both drives inactive |
| pwm | output | 1 | True drive |
| pwm_n | output | 1 | Complementary drive |

## Verification
A change of `pwm_pre` appears in the internal drive state one clock edge after it is sampled. The drive that turns on follows D edges after that sampling edge. `kill` and both polarity bits reach the pins combinationally, within the same cycle. The bench keeps a behavioural model that records the cycle index and the latched D of the last sampled change. The model is updated at each rising edge from the inputs that edge saw, and the pins are compared with it at the following falling edge. The bench drives new inputs only after that comparison, so every result is read in the cycle it is due.

// File: rtl/dtcomp_pkg.sv
package dtcomp_pkg;
    parameter int DT_W = 8;

    typedef struct packed {
        logic            lvl;   // last sampled preliminary level
        logic [DT_W-1:0] cnt;   // remaining dead-time cycles
        logic            t_on;  // true drive active (before kill/polarity)
        logic            c_on;  // complementary drive active
    } dt_state_t;
endpackage

// File: rtl/dtcomp_edge.sv
module dtcomp_edge (
    input  logic pwm_pre,
    input  logic lvl_q,
    output logic edge_hit
);
    always_comb begin
        edge_hit = pwm_pre ^ lvl_q;
    end
endmodule

// File: rtl/dtcomp_timer.sv
module dtcomp_timer
    import dtcomp_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pwm_pre,
    input  logic            edge_hit,
    input  logic [DT_W-1:0] dt,
    output logic            lvl,
    output logic            raw_t,
    output logic            raw_c
);
    localparam logic [DT_W-1:0] CNT_ZERO = '0;
    localparam logic [DT_W-1:0] CNT_ONE  = DT_W'(1);

    dt_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (edge_hit) begin
            s_d.lvl = pwm_pre;
            if (dt == CNT_ZERO) begin
                s_d.t_on = pwm_pre;
                s_d.c_on = !pwm_pre;
                s_d.cnt  = CNT_ZERO;
            end else begin
                s_d.t_on = 1'b0;
                s_d.c_on = 1'b0;
                s_d.cnt  = dt;
            end
        end else if (s_q.cnt != CNT_ZERO) begin
            s_d.cnt = s_q.cnt - CNT_ONE;
            if (s_q.cnt == CNT_ONE) begin
                s_d.t_on = s_q.lvl;
                s_d.c_on = !s_q.lvl;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.lvl  <= 1'b0;
            s_q.cnt  <= CNT_ONE;
            s_q.t_on <= 1'b0;
            s_q.c_on <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign lvl   = s_q.lvl;
    assign raw_t = s_q.t_on;
    assign raw_c = s_q.c_on;

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(raw_t && raw_c)); // R9
    AST_EDGE_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_hit && dt != CNT_ZERO) |=> (!raw_t && !raw_c)); // R2
    AST_ZERO_DT: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_hit && dt == CNT_ZERO) |=> (raw_t == $past(pwm_pre) && raw_c != $past(pwm_pre))); // R4
    AST_WINDOW_END: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_hit && s_q.cnt == CNT_ONE) |=> (raw_t == $past(s_q.lvl) && raw_c != $past(s_q.lvl))); // R3
    AST_SETTLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_hit && s_q.cnt == CNT_ZERO) |=> ($stable(raw_t) && $stable(raw_c))); // R6
endmodule

// File: rtl/dtcomp_drive.sv
module dtcomp_drive #(
    parameter int N_OUT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             kill,
    input  logic [N_OUT-1:0] raw,
    input  logic [N_OUT-1:0] inv,
    output logic [N_OUT-1:0] drv
);
    for (genvar i = 0; i < N_OUT; i++) begin : g_ch
        logic gated;
        always_comb begin
            gated  = raw[i] & ~kill;
            drv[i] = gated ^ inv[i];
        end
    end

    AST_KILL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        kill |-> (drv == inv)); // R7
endmodule

// File: rtl/dtcomp_stage.sv
module dtcomp_stage
    import dtcomp_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pwm_pre,
    input  logic [DT_W-1:0] dt_cycles,
    input  logic            inv_true,
    input  logic            inv_comp,
    input  logic            kill,
    output logic            pwm,
    output logic            pwm_n
);
    localparam int N_OUT = 2;

    logic             lvl_q;
    logic             edge_hit;
    logic             raw_t, raw_c;
    logic [N_OUT-1:0] drv;

    dtcomp_edge u_edge (
        .pwm_pre  (pwm_pre),
        .lvl_q    (lvl_q),
        .edge_hit (edge_hit)
    );

    dtcomp_timer u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwm_pre  (pwm_pre),
        .edge_hit (edge_hit),
        .dt       (dt_cycles),
        .lvl      (lvl_q),
        .raw_t    (raw_t),
        .raw_c    (raw_c)
    );

    dtcomp_drive #(.N_OUT(N_OUT)) u_drive (
        .clk   (clk),
        .rst_n (rst_n),
        .kill  (kill),
        .raw   ({raw_c, raw_t}),
        .inv   ({inv_comp, inv_true}),
        .drv   (drv)
    );

    assign pwm   = drv[0];
    assign pwm_n = drv[1];

    AST_PIN_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !((pwm ^ inv_true) && (pwm_n ^ inv_comp))); // R9
endmodule

// File: tb/sim_dtcomp_stage.sv
module sim_dtcomp_stage;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwm_pre = 1'b0;
    logic [7:0] dt_cycles = 8'd0;
    logic       inv_true = 1'b0;
    logic       inv_comp = 1'b0;
    logic       kill = 1'b0;
    logic       pwm, pwm_n;

    int checks = 0;
    int errors = 0;
    int wd = 0;

    // behavioural model state
    int cyc = 0;
    int e_cyc = -100000;
    int dte = 0;
    bit m_lvl = 1'b0;
    bit started = 1'b0;
    bit exp_t = 1'b0;
    bit exp_c = 1'b0;

    always #2.5 clk = ~clk; // 200 MHz

    dtcomp_stage u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwm_pre   (pwm_pre),
        .dt_cycles (dt_cycles),
        .inv_true  (inv_true),
        .inv_comp  (inv_comp),
        .kill      (kill),
        .pwm       (pwm),
        .pwm_n     (pwm_n)
    );

    always @(posedge clk) begin
        wd++;
        if (wd == 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic model_step();
        if (!rst_n) begin
            m_lvl = 1'b0; e_cyc = -100000; dte = 0; started = 1'b0;
        end else begin
            started = 1'b1;
            if (pwm_pre != m_lvl) begin
                m_lvl = pwm_pre; e_cyc = cyc; dte = int'(dt_cycles);
            end
        end
        exp_t = started && m_lvl && ((cyc - e_cyc) >= dte);
        exp_c = started && !m_lvl && ((cyc - e_cyc) >= dte);
        cyc++;
    endtask

    task automatic compare(input string tag);
        logic ep, en;
        ep = (exp_t && !kill) ^ inv_true;
        en = (exp_c && !kill) ^ inv_comp;
        checks++;
        if (pwm !== ep || pwm_n !== en) begin
            errors++;
            $display("FAIL %s cycle %0d: pwm/pwm_n=%b%b expected %b%b", tag, cyc, pwm, pwm_n, ep, en);
        end
        checks++;
        if (((pwm ^ inv_true) === 1'b1) && ((pwm_n ^ inv_comp) === 1'b1)) begin
            errors++;
            $display("FAIL R9 cycle %0d: both active, actual %b%b expected not both", cyc, pwm, pwm_n);
        end
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_step();
            @(negedge clk);
            compare(tag);
        end
    endtask

    initial begin
        int lfsr;
        lfsr = 32'h1ACE5;
        // R1: reset state under both polarities
        run(2, "R1");
        inv_true = 1'b1;
        run(2, "R1");
        inv_true = 1'b0;
        rst_n = 1'b1;
        // R10: first edge after release with low input
        run(3, "R10");
        // R2: rising edge, D=3, and long D=255
        dt_cycles = 8'd3; pwm_pre = 1'b1;
        run(8, "R2");
        // R3: falling edge
        pwm_pre = 1'b0;
        run(8, "R3");
        dt_cycles = 8'd255; pwm_pre = 1'b1;
        run(260, "R2");
        pwm_pre = 1'b0;
        run(260, "R3");
        // R4: zero dead time
        dt_cycles = 8'd0;
        for (int k = 0; k < 6; k++) begin
            pwm_pre = ~pwm_pre;
            run(k % 3 + 1, "R4");
        end
        pwm_pre = 1'b0;
        run(3, "R4");
        // R5: short pulse inside dead window
        dt_cycles = 8'd5; pwm_pre = 1'b1;
        run(2, "R5");
        pwm_pre = 1'b0;
        run(10, "R5");
        pwm_pre = 1'b1;
        run(4, "R5");
        pwm_pre = 1'b0;
        run(10, "R5");
        // R6: dt changes during window
        dt_cycles = 8'd4; pwm_pre = 1'b1;
        run(1, "R6");
        dt_cycles = 8'd1;
        run(7, "R6");
        dt_cycles = 8'd9;
        run(3, "R6");
        // R7: kill during window and while settled
        dt_cycles = 8'd3; pwm_pre = 1'b0;
        run(2, "R7");
        kill = 1'b1;
        run(4, "R7");
        kill = 1'b0;
        run(3, "R7");
        kill = 1'b1; pwm_pre = 1'b1;
        run(2, "R7");
        kill = 1'b0;
        run(5, "R7");
        // R8: polarity combinations
        for (int p = 0; p < 4; p++) begin
            inv_true = p[0]; inv_comp = p[1];
            pwm_pre = ~pwm_pre;
            run(3, "R8");
            kill = 1'b1;
            run(1, "R8");
            kill = 1'b0;
            run(3, "R8");
        end
        inv_true = 1'b0; inv_comp = 1'b0;
        // R9: pseudo-random activity
        for (int k = 0; k < 3000; k++) begin
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
            if (lfsr[2:0] == 3'd0) pwm_pre = ~pwm_pre;
            if (lfsr[9:6] == 4'd0) dt_cycles = 8'(lfsr[13:10]);
            kill = (lfsr[15:12] == 4'hF);
            if (lfsr[20:16] == 5'd0) inv_true = ~inv_true;
            if (lfsr[25:21] == 5'd0) inv_comp = ~inv_comp;
            run(1, "R9");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule